// File: doc/BRIEF.md
# Dual-Clock In-Order Result Reorder Buffer

This block puts results back into issue order when a variable-latency compute engine finishes its work items out of order. On the slow clock it hands out sequential tags to accepted work items. Work is accepted only while a free slot exists. The engine runs on a clock at exactly twice the slow rate, phase aligned to it. When the engine finishes an item, it returns the result with the item's tag. The block stores the result in the slot that the tag selects. Back on the slow clock, a drain pointer walks the slots in strictly ascending tag order. It presents each result on a valid/ready output only after that slot has been filled during the current lap.

A tag has one more bit than the slot index. The extra top bit is a lap bit that flips each time the tag counter wraps around the storage. Each slot keeps the lap bit of the last write it received. The drain compares that stored bit with its own lap bit. A result left over from the previous lap therefore never counts as a new one, and no clearing pass is needed. The storage itself is the fast-to-slow crossing.

The default depth comes from a worst-case latency bound. The inputs are the engine's queue depth, its pipeline stages and its maximum iterations per item. The bound is converted into slow-clock cycles, doubled for margin, and rounded up to a power of two.

Top module: `result_reorder_buffer`

## Requirements
- R1: After reset `id_avail` is 1, `issue_id` is 0 and `out_valid` is 0.
- R2: Each accepted request (`issue_req` and `id_avail` high at a slow edge) takes the tag shown on `issue_id`. The next tag is that value plus one, modulo 2·DEPTH. Bit [log2(DEPTH)] of a tag is its lap bit and the bits below it are the slot index.
- R3: A fast-clock edge with `res_valid` high stores `res_data` in slot `res_tag[log2(DEPTH)-1:0]` and marks that slot done for lap `res_tag[log2(DEPTH)]`.
- R4: Results leave on the output strictly in tag order. `out_valid` is high only when the slot at the drain pointer holds a result for the drain's current lap, whatever order the results arrived in.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged. The drain pointer advances only on a transfer.
- R6: When DEPTH tags are outstanding (issued but not yet drained), `id_avail` is 0. A request in that state is ignored and `issue_id` does not change.
- R7: After the tags wrap, a slot that still holds a result from the previous lap is not presented until a result for the new lap is written to it.
- R8: Fast-clock cycles with `res_valid` low change no slot, whatever `res_tag` and `res_data` carry.
- R9: With the default parameters (queue of 64, 20 stages, up to 20 iterations) the depth is 2048. That is 2048 tags can be outstanding before issue stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_s | input | 1 | Slow (issue and drain) clock |
| rst_s | input | 1 | Synchronous active-high reset, slow domain |
| clk_f | input | 1 | Fast (result write) clock, twice the slow rate and edge aligned |
| rst_f | input | 1 | Synchronous active-high reset, fast domain |
| issue_req | input | 1 | Request a tag for a new work item |
| id_avail | output | 1 | A free slot exists, so a request is accepted |
| issue_id | output | log2(DEPTH)+1 | Tag given to the next accepted request |
| res_valid | input | 1 | A result is presented on the fast clock |
| res_tag | input | log2(DEPTH)+1 | Tag of the presented result |
| res_data | input | DATA_W | Result payload |
| out_valid | output | 1 | In-order result available |
| out_ready | input | 1 | Consumer accepts the result |
| out_data | output | DATA_W | In-order result payload |

## Verification
The main stimulus issues a random stream of tags and returns the results in a random permutation with random delays on the fast clock. Meanwhile the consumer applies random back-pressure. Matching every output against the issue sequence separates a correct reorder from an out-of-order, duplicated or skipped result. A directed fill shows the exact depth and the stall. It returns all results in reverse order and holds back tag 0, which shows that the block waits at the head. A window with the data lines active but `res_valid` low shows that idle cycles write nothing. A single issue after the wrap shows that an old-lap slot is not mistaken for a new result.

// File: rtl/rob_pkg.sv
package rob_pkg;

    localparam int RES_W_DEF   = 32;
    localparam int QUEUE_DEF   = 64;
    localparam int STAGES_DEF  = 20;
    localparam int ITERS_DEF   = 20;

    typedef enum logic {
        LAP_EVEN = 1'b0,
        LAP_ODD  = 1'b1
    } lap_e;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int pow2_at_least(input int value);
        int p;
        p = 1;
        for (int i = 0; i < 31; i++) begin
            if (p < value) p = p * 2;
        end
        return p;
    endfunction

    // Worst case: the item sits behind a full queue plus a full pipeline,
    // every item taking the maximum iterations; counted in fast cycles,
    // converted to slow cycles, doubled for margin, rounded to a power of two.
    function automatic int rob_depth(input int queue, input int stages, input int iters);
        int fast_cycles;
        int slow_cycles;
        fast_cycles = (ceil_div(queue, stages) + 1) * stages * iters;
        slow_cycles = ceil_div(fast_cycles, 2);
        return pow2_at_least(2 * slow_cycles);
    endfunction

    function automatic lap_e lap_of(input logic top_bit);
        return top_bit ? LAP_ODD : LAP_EVEN;
    endfunction

endpackage

// File: rtl/rob_id_issuer.sv
module rob_id_issuer #(
    parameter int DEPTH = 2048,
    parameter int TAG_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             issue_req,
    input  logic [TAG_W-1:0] rd_ptr,
    output logic             id_avail,
    output logic [TAG_W-1:0] issue_id
);

    localparam logic [TAG_W-1:0] FULL_COUNT = TAG_W'(DEPTH);

    logic [TAG_W-1:0] wr_ptr;
    logic [TAG_W-1:0] occupancy;
    logic             fire;

    assign occupancy = wr_ptr - rd_ptr;
    assign id_avail  = (occupancy != FULL_COUNT);
    assign fire      = issue_req && id_avail;
    assign issue_id  = wr_ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
        end else if (fire) begin
            wr_ptr <= wr_ptr + 1'b1;
        end
    end

    // R6: outstanding tags never exceed the slot count
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
        occupancy <= FULL_COUNT);

    // R2: an accepted request moves the tag on by exactly one
    a_r2_sequential: assert property (@(posedge clk) disable iff (rst)
        fire |=> issue_id == $past(issue_id) + 1'b1);

    // R6: a stalled issuer keeps its tag
    a_r6_stall_holds: assert property (@(posedge clk) disable iff (rst)
        !id_avail |=> issue_id == $past(issue_id));

endmodule

// File: rtl/rob_slot_store.sv
module rob_slot_store #(
    parameter int DEPTH  = 2048,
    parameter int ADDR_W = 11,
    parameter int DATA_W = 32
) (
    input  logic              clk_f,
    input  logic              rst_f,
    input  logic              wr_en,
    input  logic [ADDR_W:0]   wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_idx,
    output logic              rd_flag,
    output logic [DATA_W-1:0] rd_data
);

    logic [DEPTH-1:0]  done_lap;
    logic [DATA_W-1:0] slots [DEPTH];
    logic [ADDR_W-1:0] wr_idx;
    rob_pkg::lap_e     wr_lap;

    assign wr_idx = wr_tag[ADDR_W-1:0];
    assign wr_lap = rob_pkg::lap_of(wr_tag[ADDR_W]);

    // Flags start at the odd lap so that no slot looks done for lap zero.
    always_ff @(posedge clk_f) begin
        if (rst_f) begin
            done_lap <= '1;
        end else if (wr_en) begin
            done_lap[wr_idx] <= wr_lap;
        end
    end

    always_ff @(posedge clk_f) begin
        if (wr_en) begin
            slots[wr_idx] <= wr_data;
        end
    end

    assign rd_flag = done_lap[rd_idx];
    assign rd_data = slots[rd_idx];

    // R3: a write records the lap of its tag in the addressed slot
    a_r3_lap_recorded: assert property (@(posedge clk_f) disable iff (rst_f)
        wr_en |=> done_lap[$past(wr_idx)] == $past(wr_tag[ADDR_W]));

    // R8: idle cycles leave every flag untouched
    a_r8_idle_no_change: assert property (@(posedge clk_f) disable iff (rst_f)
        !wr_en |=> $stable(done_lap));

endmodule

// File: rtl/rob_drain.sv
module rob_drain #(
    parameter int TAG_W  = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              slot_flag,
    input  logic [DATA_W-1:0] slot_data,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic [TAG_W-1:0]  rd_ptr
);

    logic fire;

    assign out_valid = (slot_flag == rd_ptr[TAG_W-1]);
    assign out_data  = slot_data;
    assign fire      = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
        end else if (fire) begin
            rd_ptr <= rd_ptr + 1'b1;
        end
    end

    // R5: a stalled result stays presented and unchanged
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R4: each transfer moves the drain to the next tag
    a_r4_step: assert property (@(posedge clk) disable iff (rst)
        fire |=> rd_ptr == $past(rd_ptr) + 1'b1);

    // R5: without a transfer the drain pointer stays put
    a_r5_ptr_hold: assert property (@(posedge clk) disable iff (rst)
        !fire |=> $stable(rd_ptr));

endmodule

// File: rtl/result_reorder_buffer.sv
module result_reorder_buffer #(
    parameter int DATA_W      = rob_pkg::RES_W_DEF,
    parameter int QUEUE_DEPTH = rob_pkg::QUEUE_DEF,
    parameter int PIPE_STAGES = rob_pkg::STAGES_DEF,
    parameter int MAX_ITERS   = rob_pkg::ITERS_DEF,
    parameter int DEPTH       = rob_pkg::rob_depth(QUEUE_DEPTH, PIPE_STAGES, MAX_ITERS)
) (
    input  logic                     clk_s,
    input  logic                     rst_s,
    input  logic                     clk_f,
    input  logic                     rst_f,
    input  logic                     issue_req,
    output logic                     id_avail,
    output logic [$clog2(DEPTH):0]   issue_id,
    input  logic                     res_valid,
    input  logic [$clog2(DEPTH):0]   res_tag,
    input  logic [DATA_W-1:0]        res_data,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic [DATA_W-1:0]        out_data
);

    localparam int ADDR_W = $clog2(DEPTH);
    localparam int TAG_W  = ADDR_W + 1;

    logic [TAG_W-1:0]  rd_ptr;
    logic              slot_flag;
    logic [DATA_W-1:0] slot_data;

    rob_id_issuer #(
        .DEPTH (DEPTH),
        .TAG_W (TAG_W)
    ) u_issuer (
        .clk       (clk_s),
        .rst       (rst_s),
        .issue_req (issue_req),
        .rd_ptr    (rd_ptr),
        .id_avail  (id_avail),
        .issue_id  (issue_id)
    );

    rob_slot_store #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_store (
        .clk_f   (clk_f),
        .rst_f   (rst_f),
        .wr_en   (res_valid),
        .wr_tag  (res_tag),
        .wr_data (res_data),
        .rd_idx  (rd_ptr[ADDR_W-1:0]),
        .rd_flag (slot_flag),
        .rd_data (slot_data)
    );

    rob_drain #(
        .TAG_W  (TAG_W),
        .DATA_W (DATA_W)
    ) u_drain (
        .clk       (clk_s),
        .rst       (rst_s),
        .slot_flag (slot_flag),
        .slot_data (slot_data),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .rd_ptr    (rd_ptr)
    );

    // R1: nothing is presented while the slow domain is in reset
    a_r1_quiet_reset: assert property (@(posedge clk_s)
        rst_s |=> !out_valid || rst_f);

endmodule

// File: tb/sim_result_reorder_buffer.sv
module sim_result_reorder_buffer;

    localparam int DEPTH = 2048;
    localparam int AW    = 11;
    localparam int TW    = 12;
    localparam int DW    = 32;
    localparam int TAGS  = 4096;
    localparam int NRAND = 4000;

    logic clk_s = 1'b0, clk_f = 1'b0, rst_s = 1'b1, rst_f = 1'b1;
    logic issue_req = 1'b0;
    logic id_avail;
    logic [TW-1:0] issue_id;
    logic res_valid = 1'b0;
    logic [TW-1:0] res_tag = '0;
    logic [DW-1:0] res_data = '0;
    logic out_valid;
    logic out_ready = 1'b0;
    logic [DW-1:0] out_data;

    int tests = 0, fails = 0;
    int seq_next = 0, out_next = 0, returned = 0;
    int pend_seq [DEPTH];
    int ol [DEPTH];
    int ol_n = 0;

    result_reorder_buffer u0 (
        .clk_s, .rst_s, .clk_f, .rst_f,
        .issue_req, .id_avail, .issue_id,
        .res_valid, .res_tag, .res_data,
        .out_valid, .out_ready, .out_data
    );

    // 125 MHz slow clock, fast clock at twice the rate, rising edges aligned
    always begin
        #2 clk_f = ~clk_f;
        if (clk_f) clk_s = ~clk_s;
    end

    function automatic logic [DW-1:0] exp_data(input int s);
        return (DW'(s) * 32'h9E37_79B1) ^ 32'hC3A5_5A3C;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic slow_step();
        @(posedge clk_s);
        #1;
    endtask

    task automatic fast_step();
        @(posedge clk_f);
        #1;
    endtask

    task automatic record_issue();
        check(issue_id == TW'(seq_next % TAGS), "R2 tag order", issue_id, seq_next % TAGS);
        pend_seq[issue_id[AW-1:0]] = seq_next;
        seq_next++;
    endtask

    task automatic return_tag(input logic [TW-1:0] tg);
        fast_step();
        res_valid = 1'b1;
        res_tag   = tg;
        res_data  = exp_data(pend_seq[tg[AW-1:0]]);
        fast_step();
        res_valid = 1'b0;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        #1_500_000;
        fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        int n;
        logic [TW-1:0] held;
        repeat (4) slow_step();
        rst_s = 1'b0;
        rst_f = 1'b0;
        slow_step();
        // R1 reset state
        check(id_avail == 1'b1, "R1 id_avail", id_avail, 1);
        check(issue_id == '0, "R1 issue_id", issue_id, 0);
        check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);

        // R6 / R9: fill without returning anything
        issue_req = 1'b1;
        n = 0;
        while (id_avail) begin
            record_issue();
            n++;
            slow_step();
        end
        check(n == DEPTH, "R9 depth", n, DEPTH);
        held = issue_id;
        slow_step();
        slow_step();
        check(issue_id == held && !id_avail, "R6 stall ignores request", issue_id, held);
        check(held == TW'(DEPTH), "R2 wrap sets lap bit", held, DEPTH);
        issue_req = 1'b0;

        // R4: reverse-order returns, head withheld
        for (int t = DEPTH - 1; t >= 1; t--) return_tag(TW'(t));
        slow_step();
        check(out_valid == 1'b0, "R4 waits for head", out_valid, 0);

        // R8: data lines busy but res_valid low
        res_tag  = '0;
        res_data = exp_data(0);
        repeat (4) fast_step();
        slow_step();
        check(out_valid == 1'b0, "R8 idle write ignored", out_valid, 0);

        return_tag('0);
        slow_step();
        check(out_valid == 1'b1, "R4 head ready", out_valid, 1);
        check(out_data == exp_data(0), "R4 head data", out_data, exp_data(0));

        // R5: back-pressure holds the result
        repeat (3) slow_step();
        check(out_valid == 1'b1 && out_data == exp_data(0), "R5 hold", out_data, exp_data(0));

        out_ready = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            check(out_valid == 1'b1 && out_data == exp_data(out_next), "R4 drain order",
                  out_data, exp_data(out_next));
            out_next++;
            slow_step();
        end
        out_ready = 1'b0;

        // R7: old-lap slot must not look done
        check(out_valid == 1'b0, "R7 stale after drain", out_valid, 0);
        check(id_avail == 1'b1, "R6 space after drain", id_avail, 1);
        issue_req = 1'b1;
        record_issue();
        slow_step();
        issue_req = 1'b0;
        check(out_valid == 1'b0, "R7 stale before new result", out_valid, 0);
        return_tag(TW'(DEPTH));
        slow_step();
        check(out_valid == 1'b1 && out_data == exp_data(DEPTH), "R7 new lap result",
              out_data, exp_data(DEPTH));
        out_ready = 1'b1;
        slow_step();
        out_next++;
        out_ready = 1'b0;
        check(out_valid == 1'b0, "R5 advance once", out_valid, 0);

        // R3 / R4: random permutation, delays and back-pressure
        returned = seq_next;
        fork
            begin
                int k;
                k = 0;
                while (k < NRAND) begin
                    bit fired;
                    logic [TW-1:0] tg;
                    issue_req = ($urandom % 4) != 0;
                    fired = issue_req && id_avail;
                    tg = issue_id;
                    if (fired) record_issue();
                    slow_step();
                    if (fired) begin
                        ol[ol_n] = int'(tg);
                        ol_n++;
                        k++;
                    end
                end
                issue_req = 1'b0;
            end
            begin
                while (returned < DEPTH + 1 + NRAND) begin
                    fast_step();
                    res_valid = 1'b0;
                    if (ol_n > 0 && ($urandom % 3) != 0) begin
                        int j;
                        logic [TW-1:0] tg;
                        j = int'($urandom % ol_n);
                        tg = TW'(ol[j]);
                        ol[j] = ol[ol_n - 1];
                        ol_n--;
                        res_valid = 1'b1;
                        res_tag   = tg;
                        res_data  = exp_data(pend_seq[tg[AW-1:0]]);
                        returned++;
                    end
                end
                fast_step();
                res_valid = 1'b0;
            end
            begin
                while (out_next < DEPTH + 1 + NRAND) begin
                    @(posedge clk_s);
                    #1;
                    out_ready = ($urandom % 3) != 0;
                    #6;
                    if (out_valid && out_ready) begin
                        check(out_data == exp_data(out_next), "R3 R4 random order",
                              out_data, exp_data(out_next));
                        out_next++;
                    end
                end
                @(posedge clk_s);
                #1;
                out_ready = 1'b0;
            end
        join
        check(out_next == seq_next, "R4 all delivered", out_next, seq_next);
        slow_step();
        check(out_valid == 1'b0 && id_avail == 1'b1, "R4 empty at end", out_valid, 0);

        summary();
        $finish;
    end

endmodule